// File: doc/BRIEF.md
# Floating-point logb-to-integer unit

This unit returns the unbiased base-2 exponent of IEEE-754 values as a signed integer that has the same width as the element. One 64-bit operand word holds four half-precision elements, two single-precision elements or one double-precision element. A 2-bit size code selects which. Each element has its own predicate bit. A predicated-off element keeps the value of the matching slice of a merge word and raises no flags.

Every element is classified as normal, subnormal, infinity, NaN or zero. A subnormal is normalised with a leading-zero count, so its exponent is exact. When the flush control is set, a subnormal is instead treated as zero. Each special class maps to a fixed saturated integer code and a fixed flag. The invalid flag and the input-denormal flag are each reported as the OR over the active elements of one operation. By default, results and flags appear one clock after a valid input, together with an output strobe. A parameter removes that register stage.

Top module: `flogb_unit`

## Requirements
- R1: For a normal element (exponent field neither all zeros nor all ones), the result is the exponent field minus the bias. The exponent field and bias are bits 14:10 and 15 in a half element, bits 30:23 and 127 in a single element, and bits 62:52 and 1023 in a double element. The fraction field is every bit below the exponent field.
- R2: For a subnormal element (exponent zero, fraction nonzero) with `ftz_en` low, the result is minus the bias minus the number of leading zeros in the fraction field, counted from its top bit. For example, the half fraction 0x001 gives -24, which is 0xFFE8.
- R3: For a subnormal element with `ftz_en` high, the result is the most negative integer of the element width. The element raises both `flag_denorm` and `flag_invalid`.
- R4: An infinity (exponent all ones, fraction zero) gives the largest positive integer of the element width and raises no flag.
- R5: A NaN (exponent all ones, fraction nonzero) or a zero gives the most negative integer of the element width and raises `flag_invalid`. It does not raise `flag_denorm`.
- R6: The sign bit has no effect on the result or on the flags.
- R7: `esize` set to 1, 2 or 3 selects 16-, 32- or 64-bit elements, and element i occupies bits [i*w +: w]. `esize` set to 0 drives `illegal` high, passes `merge_data` through to `result` and raises no flags.
- R8: Element i is active when `pred[i]` is 1. An inactive element takes its slice of `merge_data` and contributes no flags.
- R9: `flag_invalid` and `flag_denorm` are each the OR of the corresponding flag over all active elements of the operation.
- R10: With REG_OUT=1, outputs appear on the clock after an input with `in_valid` high, and `out_valid` is high for exactly that cycle. Reset clears `out_valid`, `result`, the flags and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand word is valid this cycle |
| esize | input | 2 | Element size code: 1 half, 2 single, 3 double, 0 illegal |
| src_data | input | 64 | Packed floating-point elements |
| merge_data | input | 64 | Previous destination value, kept in inactive element slices |
| pred | input | 4 | Per-element active bits; element i uses bit i |
| ftz_en | input | 1 | Treat subnormal inputs as zero |
| out_valid | output | 1 | Result word is valid |
| result | output | 64 | Packed signed exponent integers |
| flag_invalid | output | 1 | Some active element was NaN, zero or flushed |
| flag_denorm | output | 1 | Some active element was a flushed subnormal |
| illegal | output | 1 | Size code 0 was presented |

## Verification
Predicate merging and flag reduction can act in the same operation. A word can mix inactive NaN elements, which must keep their merge slices and stay silent, with active special elements, which must still raise their flags. Directed words with alternating predicate bits over NaN lanes provoke this case. Random words with per-lane class selection and random predicates repeat it many times. A bench reference function computes each slice and the ORed flags, and each output is compared against it separately. The flush path and the normalisation path also share a word when subnormals sit beside other classes under both settings of `ftz_en`.

// File: rtl/flogb_pkg.sv
package flogb_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = 16;
    localparam int SGL_W  = 32;
    localparam int DBL_W  = 64;
    localparam int NUM_H  = WORD_W / HALF_W;
    localparam int NUM_S  = WORD_W / SGL_W;
    localparam int NUM_D  = WORD_W / DBL_W;

    typedef enum logic [1:0] {
        ES_BYTE   = 2'd0,
        ES_HALF   = 2'd1,
        ES_SINGLE = 2'd2,
        ES_DOUBLE = 2'd3
    } esize_e;

    typedef enum logic [2:0] {
        C_NORMAL,
        C_SUBNORM,
        C_FLUSHED,
        C_INF,
        C_NAN_ZERO
    } fclass_e;

    typedef struct packed {
        logic invalid;
        logic denorm;
    } flags_t;

    function automatic int exp_bits(input int ew);
        if (ew == HALF_W)     return 5;
        else if (ew == SGL_W) return 8;
        else                  return 11;
    endfunction

endpackage

// File: rtl/flogb_lzc.sv
module flogb_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/flogb_lane.sv
module flogb_lane
    import flogb_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [EW-1:0] x,
    input  logic          ftz,
    input  logic          active,
    input  logic [EW-1:0] keep,
    output logic [EW-1:0] y,
    output flags_t        fl
);
    localparam int EXPW  = exp_bits(EW);
    localparam int FRACW = EW - 1 - EXPW;
    localparam int CW    = $clog2(FRACW + 1);
    localparam logic [EW-1:0] BIAS_V   = EW'((1 << (EXPW - 1)) - 1);
    localparam logic [EW-1:0] NEG_BIAS = EW'(0) - BIAS_V;
    localparam logic [EW-1:0] MAX_V    = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] MIN_V    = {1'b1, {(EW-1){1'b0}}};

    logic [EXPW-1:0]  ex;
    logic [FRACW-1:0] fr;
    logic [CW-1:0]    lz;
    fclass_e          cls;

    assign ex = x[EW-2 -: EXPW];
    assign fr = x[FRACW-1:0];

    flogb_lzc #(.W(FRACW), .CW(CW)) u_lzc (
        .vec   (fr),
        .zeros (lz)
    );

    always_comb begin
        cls = C_NORMAL;
        if (ex == '0) begin
            if (fr == '0)  cls = C_NAN_ZERO;
            else if (ftz)  cls = C_FLUSHED;
            else           cls = C_SUBNORM;
        end else if (&ex) begin
            cls = (fr == '0) ? C_INF : C_NAN_ZERO;
        end
    end

    always_comb begin
        case (cls)
            C_NORMAL:  y = EW'(ex) - BIAS_V;
            C_SUBNORM: y = NEG_BIAS - EW'(lz);
            C_INF:     y = MAX_V;
            default:   y = MIN_V;
        endcase
        fl.invalid = (cls == C_NAN_ZERO) || (cls == C_FLUSHED);
        fl.denorm  = (cls == C_FLUSHED);
        if (!active) begin
            y  = keep;
            fl = '0;
        end
    end
endmodule

// File: rtl/flogb_word.sv
module flogb_word
    import flogb_pkg::*;
(
    input  esize_e            esize,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] merge,
    input  logic [NUM_H-1:0]  pred,
    input  logic              ftz,
    output logic [WORD_W-1:0] res,
    output flags_t            fl,
    output logic              illegal
);
    logic [WORD_W-1:0] res_h, res_s, res_d;
    flags_t            fl_h [NUM_H];
    flags_t            fl_s [NUM_S];
    flags_t            fl_d [NUM_D];
    flags_t            or_h, or_s, or_d;

    for (genvar g = 0; g < NUM_H; g++) begin : g_half
        flogb_lane #(.EW(HALF_W)) u_lane (
            .x      (src[g*HALF_W +: HALF_W]),
            .ftz    (ftz),
            .active (pred[g]),
            .keep   (merge[g*HALF_W +: HALF_W]),
            .y      (res_h[g*HALF_W +: HALF_W]),
            .fl     (fl_h[g])
        );
    end

    for (genvar g = 0; g < NUM_S; g++) begin : g_single
        flogb_lane #(.EW(SGL_W)) u_lane (
            .x      (src[g*SGL_W +: SGL_W]),
            .ftz    (ftz),
            .active (pred[g]),
            .keep   (merge[g*SGL_W +: SGL_W]),
            .y      (res_s[g*SGL_W +: SGL_W]),
            .fl     (fl_s[g])
        );
    end

    for (genvar g = 0; g < NUM_D; g++) begin : g_double
        flogb_lane #(.EW(DBL_W)) u_lane (
            .x      (src[g*DBL_W +: DBL_W]),
            .ftz    (ftz),
            .active (pred[g]),
            .keep   (merge[g*DBL_W +: DBL_W]),
            .y      (res_d[g*DBL_W +: DBL_W]),
            .fl     (fl_d[g])
        );
    end

    always_comb begin
        or_h = '0;
        or_s = '0;
        or_d = '0;
        for (int i = 0; i < NUM_H; i++) or_h = or_h | fl_h[i];
        for (int i = 0; i < NUM_S; i++) or_s = or_s | fl_s[i];
        for (int i = 0; i < NUM_D; i++) or_d = or_d | fl_d[i];
    end

    always_comb begin
        illegal = 1'b0;
        case (esize)
            ES_HALF:   begin res = res_h; fl = or_h; end
            ES_SINGLE: begin res = res_s; fl = or_s; end
            ES_DOUBLE: begin res = res_d; fl = or_d; end
            default:   begin res = merge; fl = '0; illegal = 1'b1; end
        endcase
    end
endmodule

// File: rtl/flogb_unit.sv
module flogb_unit
    import flogb_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        esize,
    input  logic [WORD_W-1:0] src_data,
    input  logic [WORD_W-1:0] merge_data,
    input  logic [NUM_H-1:0]  pred,
    input  logic              ftz_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_denorm,
    output logic              illegal
);
    logic [WORD_W-1:0] w_res;
    flags_t            w_fl;
    logic              w_ill;

    flogb_word u_word (
        .esize   (esize_e'(esize)),
        .src     (src_data),
        .merge   (merge_data),
        .pred    (pred),
        .ftz     (ftz_en),
        .res     (w_res),
        .fl      (w_fl),
        .illegal (w_ill)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid    <= 1'b0;
                result       <= '0;
                flag_invalid <= 1'b0;
                flag_denorm  <= 1'b0;
                illegal      <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result       <= w_res;
                    flag_invalid <= w_fl.invalid;
                    flag_denorm  <= w_fl.denorm;
                    illegal      <= w_ill;
                end
            end
        end

        assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && esize == 2'd0) |=>
            (illegal && !flag_invalid && !flag_denorm && result == $past(merge_data)));
        assert_pred_off_merge_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && pred == '0) |=>
            (result == $past(merge_data) && !flag_invalid && !flag_denorm));
        assert_denorm_needs_flush_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !ftz_en) |=> !flag_denorm);
        assert_denorm_implies_invalid_R9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && flag_denorm) |-> flag_invalid);
    end else begin : g_comb
        assign out_valid    = in_valid;
        assign result       = w_res;
        assign flag_invalid = w_fl.invalid;
        assign flag_denorm  = w_fl.denorm;
        assign illegal      = w_ill;
    end
endmodule

// File: tb/flogb_unit_bench.sv
module flogb_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  esize = 2'd1;
    logic [63:0] src_data = '0;
    logic [63:0] merge_data = '0;
    logic [3:0]  pred = '0;
    logic        ftz_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid, flag_denorm, illegal;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flogb_unit u_flogb_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize),
        .src_data(src_data), .merge_data(merge_data), .pred(pred), .ftz_en(ftz_en),
        .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
        .flag_denorm(flag_denorm), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_lane(input logic [63:0] v, input int ew, input bit ftz,
                                     output logic [63:0] r, output bit inv, output bit den);
        int eb = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
        int fb = ew - 1 - eb;
        longint bias = (longint'(1) << (eb - 1)) - 1;
        logic [63:0] e = (v >> fb) & ((64'd1 << eb) - 1);
        logic [63:0] f = v & ((64'd1 << fb) - 1);
        logic [63:0] emax = (64'd1 << eb) - 1;
        logic [63:0] mn = 64'd1 << (ew - 1);
        logic [63:0] m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        inv = 0;
        den = 0;
        if (e == 0) begin
            if (f != 0 && !ftz) begin
                longint lz = 0;
                for (int b = fb - 1; b >= 0; b--) begin
                    if (f[b]) break;
                    lz++;
                end
                r = 64'(-bias - lz);
            end else begin
                if (f != 0) den = 1;
                inv = 1;
                r = mn;
            end
        end else if (e == emax) begin
            if (f == 0) r = mn - 1;
            else begin inv = 1; r = mn; end
        end else begin
            r = 64'(longint'(e) - bias);
        end
        r = r & m;
    endfunction

    function automatic void ref_word(input logic [1:0] es, input logic [63:0] s, input logic [63:0] mg,
                                     input logic [3:0] p, input bit ftz, output logic [63:0] res,
                                     output bit inv, output bit den, output bit ill);
        inv = 0; den = 0; ill = 0; res = '0;
        if (es == 0) begin
            ill = 1;
            res = mg;
        end else begin
            int ew = 8 << es;
            int n = 64 / ew;
            logic [63:0] m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
            for (int i = 0; i < n; i++) begin
                logic [63:0] r;
                bit li, ld;
                if (p[i]) begin
                    ref_lane((s >> (i*ew)) & m, ew, ftz, r, li, ld);
                    inv |= li;
                    den |= ld;
                end else begin
                    r = (mg >> (i*ew)) & m;
                end
                res |= (r & m) << (i*ew);
            end
        end
    endfunction

    function automatic logic [63:0] mk_elem(input int ew, input int cls);
        int eb = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
        int fb = ew - 1 - eb;
        logic [63:0] fmask = (64'd1 << fb) - 1;
        logic [63:0] emax = (64'd1 << eb) - 1;
        logic [63:0] rnd = {$urandom, $urandom};
        logic [63:0] e, f;
        logic [63:0] sg = 64'($urandom & 1);
        case (cls)
            0: begin e = 1 + (rnd[63:32] % (emax - 1)); f = rnd & fmask; end
            1: begin e = 0; f = (rnd >> ($urandom % fb)) & fmask; if (f == 0) f = 1; end
            2: begin e = emax; f = 0; end
            3: begin e = emax; f = rnd & fmask; if (f == 0) f = 1; end
            default: begin e = 0; f = 0; end
        endcase
        return (sg << (ew - 1)) | (e << fb) | f;
    endfunction

    task automatic run(input logic [1:0] es, input logic [63:0] s, input logic [63:0] mg,
                       input logic [3:0] p, input bit ftz, input string req);
        logic [63:0] er;
        bit ei, ed, el;
        ref_word(es, s, mg, p, ftz, er, ei, ed, el);
        esize = es; src_data = s; merge_data = mg; pred = p; ftz_en = ftz; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {req, " R10 out_valid"}, 64'(out_valid), 64'd1);
        check(result == er, {req, " result"}, result, er);
        check(flag_invalid == ei, {req, " invalid"}, 64'(flag_invalid), 64'(ei));
        check(flag_denorm == ed, {req, " denorm"}, 64'(flag_denorm), 64'(ed));
        check(illegal == el, {req, " illegal"}, 64'(illegal), 64'(el));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 0 && result == 0 && !flag_invalid && !flag_denorm && !illegal,
              "R10 reset state", result, 64'd0);

        // R1 R2 R4 R6: 1.0, -1.0, min subnormal, +inf halves
        run(2'd1, 64'h7C00_0001_BC00_3C00, 64'h0, 4'hF, 1'b0, "R1 R2 R4 R6 half");
        check(result == 64'h7FFF_FFE8_0000_0000, "R2 half -24", result, 64'h7FFF_FFE8_0000_0000);
        // R3: flush same word
        run(2'd1, 64'h7C00_0001_BC00_3C00, 64'h0, 4'hF, 1'b1, "R3 flush half");
        check(result == 64'h7FFF_8000_0000_0000 && flag_denorm, "R3 flushed value", result, 64'h7FFF_8000_0000_0000);
        // R5 NaN and zero singles
        run(2'd2, 64'h7FC0_0000_8000_0000, 64'h0, 4'h3, 1'b0, "R5 nan zero single");
        check(result == 64'h8000_0000_8000_0000, "R5 min codes", result, 64'h8000_0000_8000_0000);
        // R1 R2 doubles
        run(2'd3, 64'h3FF0_0000_0000_0000, 64'h0, 4'h1, 1'b0, "R1 double one");
        run(2'd3, 64'h0000_0000_0000_0001, 64'h0, 4'h1, 1'b0, "R2 double min sub");
        check(result == 64'hFFFF_FFFF_FFFF_FBCE, "R2 double -1074", result, 64'hFFFF_FFFF_FFFF_FBCE);
        // R7 illegal size
        run(2'd0, 64'h3C00_3C00_3C00_3C00, 64'h1234_5678_9ABC_DEF0, 4'hF, 1'b0, "R7 illegal");
        // R8 R9: inactive NaN lanes keep merge, active zero flags
        run(2'd1, 64'h7E00_0000_7E00_3C00, 64'hAAAA_BBBB_CCCC_DDDD, 4'b0101, 1'b0, "R8 R9 merge");
        check(result == 64'hAAAA_8000_CCCC_0000, "R8 merged slices", result, 64'hAAAA_8000_CCCC_0000);
        run(2'd1, 64'h7E00_7E00_7E00_7E00, 64'h5555_6666_7777_8888, 4'b0000, 1'b0, "R8 all off");
        // R9 flag OR across singles
        run(2'd2, 64'h3F80_0000_7F80_0001, 64'h0, 4'h3, 1'b0, "R9 or single");
        // R10 idle cycle
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle no valid", 64'(out_valid), 64'd0);

        for (int k = 0; k < 500; k++) begin
            logic [1:0] es = ($urandom % 16 == 0) ? 2'd0 : 2'(1 + $urandom % 3);
            int ew = (es == 0) ? 16 : (8 << es);
            logic [63:0] s = '0;
            logic [63:0] m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
            for (int i = 0; i < 64 / ew; i++)
                s |= (mk_elem(ew, int'($urandom % 5)) & m) << (i*ew);
            run(es, s, {$urandom, $urandom}, 4'($urandom), 1'($urandom), "RAND R1 R2 R3 R4 R5 R6 R7 R8 R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule